// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a serial port that a control register switches between four operating modes. Mode 0 is a synchronous shifter: it drives a shift clock and moves eight bits least significant first. Mode 1 is an asynchronous UART with eight data bits. Modes 2 and 3 are asynchronous UARTs that add a ninth data bit. Mode 2 runs from a fixed clock-divided tick. Modes 1 and 3 run from an external baud tick. The ninth bit marks address frames in multi-drop networks. A receive filter gate then drops frames that are not meant for this node.

Software uses a small register port. One select value reaches the control register, which holds the mode, the filter enable, the receive enable, the ninth bits and the two interrupt flags. The other select value reaches the data register. Writing it starts a transmission. Reading it returns the last byte accepted by the receiver. An address-match result from a separate filter is one of the inputs. Baud generation is outside the block.

Top module: `serial_port_multimode`

## Requirements
- R1: After reset the control register reads 00h, the receive buffer reads 00h, txd and sclk are high, and both interrupt outputs are low.
- R2: In mode 1, a data write sends a 10-bit frame: a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts 16 baud ticks. TI (control bit 1) becomes 1 after the stop bit.
- R3: In modes 2 and 3 the frame carries a ninth bit between the data and the stop bit. Its value is TB8 (control bit 3) at the moment of the data write. A later change to TB8 does not alter the frame in flight.
- R4: Mode 2 times every bit with 16 fixed ticks and ignores the baud tick. Mode 3 uses the baud tick.
- R5: A data write made while a frame is still being sent is ignored. No second frame follows.
- R6: In mode 1 with REN (control bit 4) set, a received frame loads the receive buffer. The stop bit goes into RB8 (control bit 2) and RI (control bit 0) becomes 1.
- R7: In mode 1 with SM2 (control bit 5) set, a frame whose stop bit is low leaves RI at 0 and the buffer unchanged. A frame with a high stop bit is still accepted.
- R8: In modes 2 and 3 with SM2 set, RI is set only when the ninth bit is 1 and the address-match input is high. With SM2 clear, every frame is accepted. In both cases RB8 takes the ninth bit.
- R9: With REN clear, frames on rxd leave RI and the buffer unchanged.
- R10: A low pulse on rxd that is high again by mid-bit is rejected as a false start. The receiver then accepts the next real frame.
- R11: While RI is 1, a newly completed frame is discarded and the buffer keeps its old value.
- R12: In mode 0, a data write shifts the eight bits out on txd, least significant first. Each bit gets one sclk pulse, and the pulses are 8 fixed ticks apart. sclk idles high, and TI becomes 1 after the eighth bit.
- R13: In mode 0, setting REN while RI is 0 starts a receive. rxd is sampled on each rising sclk edge, least significant bit first. RI becomes 1 after the eighth bit.
- R14: A control write replaces all eight bits, so writing 0 to TI or RI clears it. If hardware sets a flag in the same cycle, the hardware set wins. Read data appears on bus_rdata one cycle after bus_sel is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| baud_tick | input | 1 | 16x tick for modes 1 and 3 |
| fix_tick | input | 1 | Clock-divided tick for modes 0 and 2 |
| addr_match | input | 1 | Result from the external address filter |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line (shifter data in mode 0) |
| sclk | output | 1 | Shift clock for mode 0 |
| tx_irq | output | 1 | Copy of TI |
| rx_irq | output | 1 | Copy of RI |

## Verification
Each result has a fixed delay after its stimulus:
- Register reads return one cycle after the select changes.
- A transmit frame begins on the first edge after the data write.
- TI and RI rise one cycle after the last bit of a frame ends.
- Receive decisions lag the line by the two-flop synchronizer plus up to one tick.

The bench samples serial bits at mid-bit, using bit periods computed from the tick spacing it generates. It waits a margin of several ticks past each frame end before it reads a flag or the buffer. In mode 0 it samples each bit and measures the pulse spacing at the rising sclk edges it observes.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    M_SHIFT  = 2'd0,
    M_UART8  = 2'd1,
    M_UART9F = 2'd2,
    M_UART9V = 2'd3
  } sp_mode_e;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/sp_uart_tx.sv
module sp_uart_tx #(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          load,
  input  logic          nine,
  input  logic          bit9,
  input  logic [DW-1:0] data,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OS);

  logic [FW-1:0] sh;
  logic [LW-1:0] left;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        sh   <= nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
        left <= nine ? LW'(FW) : LW'(FW - 1);
        cnt  <= '0;
        txd  <= 1'b0;
        busy <= 1'b1;
      end
    end else if (os_tick) begin
      cnt <= (cnt == CW'(OS - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(OS - 1)) begin
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
        if (left == LW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          txd  <= 1'b1;
        end else begin
          txd <= sh[1];
        end
      end
    end
  end

  // R1: line is high whenever no frame is in flight
  p_txd_idle_r1: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
endmodule

// File: rtl/sp_uart_rx.sv
module sp_uart_rx
  import sp_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          os_tick,
  input  logic          nine,
  input  logic          rxd_s,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok
);
  localparam int CW  = $clog2(OS);
  localparam int IW  = $clog2(DW + 3);
  localparam int MID = OS / 2;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [2:0]    samp;
  logic          bitv;
  logic [IW-1:0] last;

  assign bitv = vote3(samp);
  assign last = nine ? IW'(DW + 2) : IW'(DW + 1);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      samp    <= '0;
      data    <= '0;
      bit9    <= 1'b0;
      stop_ok <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (!rxd_s) begin
        busy <= 1'b1;
        cnt  <= '0;
        idx  <= '0;
      end
    end else if (os_tick) begin
      cnt <= (cnt == CW'(OS - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(MID - 1) || cnt == CW'(MID) || cnt == CW'(MID + 1))
        samp <= {samp[1:0], rxd_s};
      if (cnt == CW'(OS - 1)) begin
        idx <= idx + 1'b1;
        if (idx == '0) begin
          if (bitv) busy <= 1'b0;           // false start
        end else if (idx <= IW'(DW)) begin
          data <= {bitv, data[DW-1:1]};
        end else begin
          if (idx == IW'(DW + 1)) bit9 <= bitv;
          if (idx == last) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            stop_ok <= bitv;
          end
        end
      end
    end
  end

  // R9: a cleared enable drops any frame in progress
  p_rx_off_r9: assert property (@(posedge clk) disable iff (rst) !en |=> !busy);
endmodule

// File: rtl/sp_shift0.sv
module sp_shift0 #(
  parameter int DW = 8,
  parameter int PH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] data,
  input  logic          rxd_s,
  output logic          txd,
  output logic          sclk,
  output logic          busy,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data
);
  localparam int PW   = $clog2(PH);
  localparam int BW   = $clog2(DW);
  localparam int HALF = PH / 2;

  logic          is_rx;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;

  assign rx_data = sh;

  always_ff @(posedge clk) begin
    tx_done <= 1'b0;
    rx_done <= 1'b0;
    if (rst) begin
      busy  <= 1'b0;
      is_rx <= 1'b0;
      ph    <= '0;
      bitn  <= '0;
      sh    <= '0;
      txd   <= 1'b1;
      sclk  <= 1'b1;
    end else if (!busy) begin
      if (start_tx) begin
        busy  <= 1'b1;
        is_rx <= 1'b0;
        ph    <= '0;
        bitn  <= '0;
        sh    <= data;
        txd   <= data[0];
        sclk  <= 1'b0;
      end else if (start_rx) begin
        busy  <= 1'b1;
        is_rx <= 1'b1;
        ph    <= '0;
        bitn  <= '0;
        txd   <= 1'b1;
        sclk  <= 1'b0;
      end
    end else if (tick) begin
      ph <= (ph == PW'(PH - 1)) ? '0 : ph + 1'b1;
      if (ph == PW'(HALF - 1)) begin
        sclk <= 1'b1;
        if (is_rx) sh <= {rxd_s, sh[DW-1:1]};
      end
      if (ph == PW'(PH - 1)) begin
        if (bitn == BW'(DW - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
          if (is_rx) rx_done <= 1'b1;
          else       tx_done <= 1'b1;
        end else begin
          bitn <= bitn + 1'b1;
          sclk <= 1'b0;
          if (!is_rx) begin
            sh  <= {1'b0, sh[DW-1:1]};
            txd <= sh[1];
          end
        end
      end
    end
  end

  // R12: shift clock rests high between transfers
  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (rst) !busy |-> sclk);
  // R12: data line rests high between transfers
  p_m0_txd_idle_r12: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
endmodule

// File: rtl/serial_port_multimode.sv
module serial_port_multimode
  import sp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OS    = 16,
  parameter int M0_PH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          baud_tick,
  input  logic          fix_tick,
  input  logic          addr_match,
  input  logic          rxd,
  output logic          txd,
  output logic          sclk,
  output logic          tx_irq,
  output logic          rx_irq
);
  sp_mode_e      mode_q;
  logic          sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [DW-1:0] rxbuf;
  logic [1:0]    rx_sync;
  logic          rxd_s;

  logic wr_ctrl, wr_data, is_m0, nine, os_tick;
  logic u_busy, u_done, u_txd;
  logic r_done, r_bit9, r_stop_ok;
  logic [DW-1:0] r_data;
  logic m0_busy, m0_txd, m0_sclk, m0_tx_done, m0_rx_done;
  logic [DW-1:0] m0_data;
  logic start_u, start_m0_tx, start_m0_rx, u_ok, rx_accept, tx_done_any;
  logic [7:0] ctrl8;

  assign rxd_s   = rx_sync[1];
  assign wr_ctrl = bus_we & ~bus_sel;
  assign wr_data = bus_we & bus_sel;
  assign is_m0   = (mode_q == M_SHIFT);
  assign nine    = mode_q[1];
  assign os_tick = (mode_q == M_UART9F) ? fix_tick : baud_tick;

  assign start_u     = wr_data & ~is_m0 & ~u_busy & ~m0_busy;
  assign start_m0_tx = wr_data & is_m0 & ~u_busy & ~m0_busy;
  assign start_m0_rx = is_m0 & ren_q & ~ri_q & ~m0_busy & ~u_busy & ~wr_data & ~m0_rx_done;

  assign u_ok        = (mode_q == M_UART8) ? (~sm2_q | r_stop_ok)
                                           : (~sm2_q | (r_bit9 & addr_match));
  assign rx_accept   = ~ri_q & ((r_done & u_ok) | m0_rx_done);
  assign tx_done_any = u_done | m0_tx_done;
  assign ctrl8       = {mode_q, sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rxd};
  end

  sp_uart_tx #(.DW(DW), .OS(OS)) u_tx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .load(start_u), .nine(nine),
    .bit9(tb8_q), .data(bus_wdata), .txd(u_txd), .busy(u_busy), .done(u_done)
  );

  sp_uart_rx #(.DW(DW), .OS(OS)) u_rx (
    .clk(clk), .rst(rst), .en(ren_q & ~is_m0), .os_tick(os_tick), .nine(nine),
    .rxd_s(rxd_s), .done(r_done), .data(r_data), .bit9(r_bit9), .stop_ok(r_stop_ok)
  );

  sp_shift0 #(.DW(DW), .PH(M0_PH)) u_m0 (
    .clk(clk), .rst(rst), .tick(fix_tick), .start_tx(start_m0_tx),
    .start_rx(start_m0_rx), .data(bus_wdata), .rxd_s(rxd_s), .txd(m0_txd),
    .sclk(m0_sclk), .busy(m0_busy), .tx_done(m0_tx_done),
    .rx_done(m0_rx_done), .rx_data(m0_data)
  );

  // Control register: software write first, hardware sets override it.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_SHIFT;
      sm2_q  <= 1'b0;
      ren_q  <= 1'b0;
      tb8_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rxbuf  <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= sp_mode_e'(bus_wdata[7:6]);
        sm2_q  <= bus_wdata[5];
        ren_q  <= bus_wdata[4];
        tb8_q  <= bus_wdata[3];
        rb8_q  <= bus_wdata[2];
        ti_q   <= bus_wdata[1];
        ri_q   <= bus_wdata[0];
      end
      if (tx_done_any) ti_q <= 1'b1;
      if (rx_accept) begin
        ri_q  <= 1'b1;
        rxbuf <= m0_rx_done ? m0_data : r_data;
        if (!m0_rx_done) rb8_q <= r_bit9;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_sel ? rxbuf : DW'(ctrl8);
  end

  assign txd    = is_m0 ? m0_txd : u_txd;
  assign sclk   = m0_sclk;
  assign tx_irq = ti_q;
  assign rx_irq = ri_q;

  // R2: end of any transmit frame raises TI on the next edge
  p_ti_set_r2: assert property (@(posedge clk) disable iff (rst) tx_done_any |=> ti_q);
  // R11: RI can only fall through a control write
  p_ri_sticky_r11: assert property (@(posedge clk) disable iff (rst) (ri_q && !wr_ctrl) |=> ri_q);
  // R7: a frame with a bad stop bit under the filter leaves the buffer alone
  p_bad_stop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (r_done && sm2_q && mode_q == M_UART8 && !r_stop_ok && !m0_rx_done) |=> $stable(rxbuf));
  // R8: filtered ninth-bit modes reject frames with a low ninth bit
  p_nine_filter_r8: assert property (@(posedge clk) disable iff (rst)
    (r_done && sm2_q && nine && !r_bit9 && !ri_q && !wr_ctrl) |=> !ri_q);
endmodule

// File: tb/tb_serial_port_multimode.sv
`timescale 1ns/1ps
module tb_serial_port_multimode;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic baud_tick = 1'b0, fix_tick = 1'b0, addr_match = 1'b0, rxd = 1'b1;
  logic txd, sclk, tx_irq, rx_irq;
  int n_run = 0, n_fail = 0, cyc = 0;

  localparam int BP = 64;  // baud tick every 4 clocks, 16 per bit
  localparam int FP = 32;  // fix tick every 2 clocks, 16 per bit

  serial_port_multimode dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .baud_tick(baud_tick), .fix_tick(fix_tick),
    .addr_match(addr_match), .rxd(rxd), .txd(txd), .sclk(sclk),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = (cyc % 4 == 0);
      fix_tick  = (cyc % 2 == 0);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); bus_sel = sel;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic cap(input int n, input int per, output logic [15:0] bits, output logic ok);
    int t = 0;
    bits = '0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    ok = (t < 5000);
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      repeat (per) @(negedge clk);
    end
  endtask

  task automatic send(input logic [15:0] bits, input int n, input int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = bits[i];
      repeat (per - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic wait_rise(output int at, output logic ok);
    logic prev;
    int t = 0;
    prev = sclk;
    ok = 1'b0;
    while (t < 2000 && !ok) begin
      @(negedge clk); t++;
      if (!prev && sclk) ok = 1'b1;
      prev = sclk;
    end
    at = cyc;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
    rd(1'b1, d); chk("R1 rxbuf", d, 8'h00);
    chk("R1 txd/sclk/irq", {txd, sclk, tx_irq, rx_irq}, 4'b1100);
  endtask

  task automatic t_tx_mode1;
    logic [15:0] b; logic ok; logic [7:0] d;
    wr(1'b0, 8'h40);
    wr(1'b1, 8'hA5);
    cap(10, BP, b, ok);
    chk("R2 start found", ok, 1);
    chk("R2 frame", b[9:0], {1'b1, 8'hA5, 1'b0});
    rd(1'b0, d); chk("R2 TI set", d, 8'h42);
    wr(1'b0, 8'h40);
    rd(1'b0, d); chk("R14 TI cleared by write", d, 8'h40);
  endtask

  task automatic t_tx_mode3_tb8;
    logic [15:0] b; logic ok; logic [7:0] d;
    wr(1'b0, 8'hC8);
    wr(1'b1, 8'h3C);
    wr(1'b0, 8'hC0);          // TB8 cleared mid-frame
    wr(1'b1, 8'hFF);          // ignored: busy
    cap(11, BP, b, ok);
    chk("R3 frame with ninth bit from write time", b[10:0], {2'b11, 8'h3C, 1'b0});
    ok = 1'b1;
    for (int i = 0; i < 2 * BP; i++) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
    chk("R5 no second frame", ok, 1);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_tx_mode2;
    logic [15:0] b; logic ok;
    wr(1'b0, 8'h88);
    wr(1'b1, 8'h5A);
    cap(11, FP, b, ok);
    chk("R4 mode 2 fixed-rate frame", b[10:0], {2'b11, 8'h5A, 1'b0});
    wr(1'b0, 8'h80);
  endtask

  task automatic t_rx_mode1;
    logic [7:0] d;
    wr(1'b0, 8'h50);
    send({6'b0, 1'b1, 8'h96, 1'b0}, 10, BP);
    rd(1'b0, d); chk("R6 ctrl RI and RB8", d, 8'h55);
    rd(1'b1, d); chk("R6 buffer", d, 8'h96);
    send({6'b0, 1'b1, 8'h11, 1'b0}, 10, BP);
    rd(1'b1, d); chk("R11 buffer kept while RI", d, 8'h96);
    wr(1'b0, 8'h50);
  endtask

  task automatic t_rx_sm2_stop;
    logic [7:0] d;
    wr(1'b0, 8'h70);
    send({6'b0, 1'b0, 8'h22, 1'b0}, 10, BP);
    rd(1'b0, d); chk("R7 no RI on bad stop", d[0], 1'b0);
    rd(1'b1, d); chk("R7 buffer unchanged", d, 8'h96);
    send({6'b0, 1'b1, 8'h33, 1'b0}, 10, BP);
    rd(1'b1, d); chk("R7 good stop accepted", d, 8'h33);
    wr(1'b0, 8'hF0);
  endtask

  task automatic t_rx_mode3;
    logic [7:0] d;
    addr_match = 1'b1;
    send({5'b0, 1'b1, 1'b0, 8'h44, 1'b0}, 11, BP);
    rd(1'b0, d); chk("R8 ninth bit 0 filtered", d[0], 1'b0);
    addr_match = 1'b0;
    send({5'b0, 1'b1, 1'b1, 8'h45, 1'b0}, 11, BP);
    rd(1'b0, d); chk("R8 no address match filtered", d[0], 1'b0);
    addr_match = 1'b1;
    send({5'b0, 1'b1, 1'b1, 8'h46, 1'b0}, 11, BP);
    rd(1'b0, d); chk("R8 accepted ctrl", d, 8'hF5);
    rd(1'b1, d); chk("R8 accepted buffer", d, 8'h46);
    wr(1'b0, 8'hD0);
    addr_match = 1'b0;
    send({5'b0, 1'b1, 1'b0, 8'h47, 1'b0}, 11, BP);
    rd(1'b0, d); chk("R8 unfiltered ctrl RB8=0", d, 8'hD1);
    rd(1'b1, d); chk("R8 unfiltered buffer", d, 8'h47);
  endtask

  task automatic t_rx_disabled;
    logic [7:0] d;
    wr(1'b0, 8'h40);
    send({6'b0, 1'b1, 8'h99, 1'b0}, 10, BP);
    rd(1'b0, d); chk("R9 RI stays 0", d, 8'h40);
    rd(1'b1, d); chk("R9 buffer unchanged", d, 8'h47);
  endtask

  task automatic t_false_start;
    logic [7:0] d;
    wr(1'b0, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    rd(1'b0, d); chk("R10 glitch gives no RI", d[0], 1'b0);
    send({6'b0, 1'b1, 8'h6B, 1'b0}, 10, BP);
    rd(1'b1, d); chk("R10 next frame received", d, 8'h6B);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_m0_tx;
    logic [7:0] got, d; logic ok, all_ok; int at, first, prev_at, gap_bad;
    all_ok = 1'b1; gap_bad = 0; first = 0; prev_at = 0; got = '0;
    wr(1'b1, 8'hC3);
    for (int i = 0; i < 8; i++) begin
      wait_rise(at, ok);
      if (!ok) all_ok = 1'b0;
      got[i] = txd;
      if (i == 0) first = at;
      else if (at - prev_at != 16) gap_bad++;
      prev_at = at;
    end
    chk("R12 pulses seen", all_ok, 1);
    chk("R12 bits LSB first", got, 8'hC3);
    chk("R12 pulse spacing errors", gap_bad, 0);
    chk("R12 span of 8 pulses", prev_at - first, 112);
    repeat (20) @(negedge clk);
    chk("R12 sclk idle high", sclk, 1'b1);
    rd(1'b0, d); chk("R12 TI set", d, 8'h02);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_m0_rx;
    logic [7:0] v, d; logic ok, all_ok; int at;
    v = 8'hB4; all_ok = 1'b1;
    @(negedge clk); rxd = v[0];
    wr(1'b0, 8'h10);
    for (int i = 0; i < 8; i++) begin
      wait_rise(at, ok);
      if (!ok) all_ok = 1'b0;
      repeat (2) @(negedge clk);
      rxd = (i < 7) ? v[i+1] : 1'b1;
    end
    repeat (20) @(negedge clk);
    chk("R13 pulses seen", all_ok, 1);
    rd(1'b0, d); chk("R13 RI set", d, 8'h11);
    rd(1'b1, d); chk("R13 buffer", d, 8'hB4);
    wr(1'b0, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_mode1();
    t_tx_mode3_tb8();
    t_tx_mode2();
    t_rx_mode1();
    t_rx_sm2_stop();
    t_rx_mode3();
    t_rx_disabled();
    t_false_start();
    t_m0_tx();
    t_m0_rx();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d cycles expected=finish before limit", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule